// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block steps a small processor core between its normal run mode and two low-power modes. A decoded instruction request places the core in a low-power mode, and that request counts only once the instruction has completed writeback. An interrupt brings the core back to run mode. The block produces the clock enables that the chip's clock gating cells use: one for the core clocks and one for the peripheral clock. It also produces the DRAM self-refresh request, the always-on enables for the PLL, the timer clock and the interrupt clock, and a two-bit mode code.

Entering standby stops only the core, and only after the internal system bus has gone idle. Peripherals and DMA keep running. Entering suspend takes one more step. The block first asks the DRAM controller to enter self-refresh and waits for its acknowledge. It then waits for bus idle, and finally stops both the core clocks and the peripheral clock. On wake from suspend, the block first restores the peripheral clock and drops the self-refresh request. The core clocks return only after the DRAM controller has withdrawn its acknowledge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: An asynchronous reset puts the block in run mode: mode code 00, core and peripheral enables high, self-refresh request low.
- R2: A standby request has an effect only in a cycle where writeback completion is also high. Without that qualifier it is ignored.
- R3: After an accepted standby request, the core enable falls in the cycle after bus idle is seen. In standby the mode code is 01, the peripheral enable stays high and no self-refresh is requested.
- R4: In standby, an interrupt returns the block to run mode (code 00, core enable high) one cycle later.
- R5: An accepted suspend request raises the self-refresh request at once. The block then waits for the self-refresh acknowledge, then for bus idle. After that, the core and peripheral enables both fall and the mode code reads 10.
- R6: An interrupt in suspend drops the self-refresh request and raises the peripheral enable in the next cycle, with the core still stopped and the code at 10. The core enable returns, with code 00, one cycle after the acknowledge is seen low.
- R7: A standby or suspend request that arrives during an entry sequence or in a low-power mode leaves the state unchanged.
- R8: An interrupt during any entry step before the clocks are gated aborts the entry. One cycle later the block is back in run mode with the self-refresh request low.
- R9: If standby and suspend requests are qualified in the same cycle, suspend is taken.
- R10: The PLL, timer clock and interrupt clock enables are high in every mode and at every sequence step.
- R11: The mode code uses 00 run, 01 standby, 10 suspend, 11 hibernate. This block never produces 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_req_i | input | 1 | Decoded standby request |
| susp_req_i | input | 1 | Decoded suspend request |
| wb_done_i | input | 1 | Requesting instruction has completed writeback |
| bus_idle_i | input | 1 | Internal system bus idle |
| sr_ack_i | input | 1 | DRAM is in self-refresh |
| irq_i | input | 1 | Pending interrupt |
| core_clk_en_o | output | 1 | Core clock enable, gated clock held high when low |
| peri_clk_en_o | output | 1 | Peripheral clock enable |
| sr_req_o | output | 1 | DRAM self-refresh request |
| pll_en_o | output | 1 | PLL enable |
| tmr_clk_en_o | output | 1 | Timer clock enable |
| irq_clk_en_o | output | 1 | Interrupt clock enable |
| mode_o | output | 2 | Current mode code |

## Verification
The bench builds the block with its default of suspend over standby, `SUSP_FIRST = 1`. With that setting, requests that collide in one cycle can be checked to resolve to the self-refresh path. Under this default the bench can reach every sequence step. This covers the wait for acknowledge, the wait for bus idle and the wake wait on a still-asserted acknowledge. It also covers aborts from each entry step and a reset taken while deep in suspend.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_STBY = 2'b01,
    MODE_SUSP = 2'b10,
    MODE_HIBR = 2'b11
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_STBY_WAIT,
    ST_STBY,
    ST_SR_WAIT,
    ST_IDLE_WAIT,
    ST_SUSP,
    ST_WAKE
  } pwr_state_e;

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_STBY,
    REQ_SUSP
  } pwr_req_e;
endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
  import pwr_mode_pkg::*;
#(
  parameter bit SUSP_FIRST = 1'b1
) (
  input  logic     stby_req_i,
  input  logic     susp_req_i,
  input  logic     wb_done_i,
  output pwr_req_e req_o
);
  logic stby_q, susp_q;
  assign stby_q = stby_req_i & wb_done_i;
  assign susp_q = susp_req_i & wb_done_i;

  generate
    if (SUSP_FIRST) begin : g_susp_first
      always_comb begin
        if (susp_q)      req_o = REQ_SUSP;
        else if (stby_q) req_o = REQ_STBY;
        else             req_o = REQ_NONE;
      end
    end else begin : g_stby_first
      always_comb begin
        if (stby_q)      req_o = REQ_STBY;
        else if (susp_q) req_o = REQ_SUSP;
        else             req_o = REQ_NONE;
      end
    end
  endgenerate
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_req_e   req_i,
  input  logic       bus_idle_i,
  input  logic       sr_ack_i,
  input  logic       irq_i,
  output pwr_state_e state_o
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (req_i == REQ_SUSP)      state_d = ST_SR_WAIT;
        else if (req_i == REQ_STBY) state_d = ST_STBY_WAIT;
      end
      ST_STBY_WAIT: begin
        if (irq_i)           state_d = ST_RUN;
        else if (bus_idle_i) state_d = ST_STBY;
      end
      ST_STBY:      if (irq_i) state_d = ST_RUN;
      ST_SR_WAIT: begin
        if (irq_i)         state_d = ST_RUN;
        else if (sr_ack_i) state_d = ST_IDLE_WAIT;
      end
      ST_IDLE_WAIT: begin
        if (irq_i)           state_d = ST_RUN;
        else if (bus_idle_i) state_d = ST_SUSP;
      end
      ST_SUSP:      if (irq_i) state_d = ST_WAKE;
      // core stays stopped until DRAM has left self-refresh
      ST_WAKE:      if (!sr_ack_i) state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_stby_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && !irq_i) |=> state_q == ST_STBY);
  assert_susp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && !irq_i) |=> state_q == ST_SUSP);
  assert_stby_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && irq_i) |=> state_q == ST_RUN);
  assert_entry_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_STBY_WAIT || state_q == ST_SR_WAIT || state_q == ST_IDLE_WAIT)
     && irq_i) |=> state_q == ST_RUN);
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_mode_pkg::*;
(
  input  pwr_state_e state_i,
  output logic       core_clk_en_o,
  output logic       peri_clk_en_o,
  output logic       sr_req_o,
  output pwr_mode_e  mode_o
);
  always_comb begin
    core_clk_en_o = 1'b1;
    peri_clk_en_o = 1'b1;
    sr_req_o      = 1'b0;
    mode_o        = MODE_FULL;
    unique case (state_i)
      ST_STBY: begin
        core_clk_en_o = 1'b0;
        mode_o        = MODE_STBY;
      end
      ST_SR_WAIT, ST_IDLE_WAIT: sr_req_o = 1'b1;
      ST_SUSP: begin
        core_clk_en_o = 1'b0;
        peri_clk_en_o = 1'b0;
        sr_req_o      = 1'b1;
        mode_o        = MODE_SUSP;
      end
      ST_WAKE: begin
        core_clk_en_o = 1'b0;
        mode_o        = MODE_SUSP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter bit SUSP_FIRST = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_req_i,
  input  logic       susp_req_i,
  input  logic       wb_done_i,
  input  logic       bus_idle_i,
  input  logic       sr_ack_i,
  input  logic       irq_i,
  output logic       core_clk_en_o,
  output logic       peri_clk_en_o,
  output logic       sr_req_o,
  output logic       pll_en_o,
  output logic       tmr_clk_en_o,
  output logic       irq_clk_en_o,
  output logic [1:0] mode_o
);
  pwr_req_e   req;
  pwr_state_e state;
  pwr_mode_e  mode;

  pwr_req_decode #(.SUSP_FIRST(SUSP_FIRST)) i_req (
    .stby_req_i(stby_req_i),
    .susp_req_i(susp_req_i),
    .wb_done_i (wb_done_i),
    .req_o     (req)
  );

  pwr_mode_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .bus_idle_i(bus_idle_i),
    .sr_ack_i  (sr_ack_i),
    .irq_i     (irq_i),
    .state_o   (state)
  );

  pwr_out_decode i_out (
    .state_i      (state),
    .core_clk_en_o(core_clk_en_o),
    .peri_clk_en_o(peri_clk_en_o),
    .sr_req_o     (sr_req_o),
    .mode_o       (mode)
  );

  // always-on domain
  assign pll_en_o     = 1'b1;
  assign tmr_clk_en_o = 1'b1;
  assign irq_clk_en_o = 1'b1;
  assign mode_o       = mode;

  assert_gate_after_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_clk_en_o) |-> $past(bus_idle_i));
  assert_stby_peri_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_STBY |-> (peri_clk_en_o && !sr_req_o));
  assert_susp_core_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_SUSP |-> !core_clk_en_o);
  assert_sr_before_peri_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(peri_clk_en_o) |-> $past(sr_req_o));
  assert_wake_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) |-> (peri_clk_en_o && !sr_req_o));
  assert_no_hibr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != MODE_HIBR);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby, susp, wb, idle, ack, irq;
  logic core_en, peri_en, sr_req, pll_en, tmr_en, irqc_en;
  logic [1:0] mode;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .stby_req_i(stby), .susp_req_i(susp),
    .wb_done_i(wb), .bus_idle_i(idle), .sr_ack_i(ack), .irq_i(irq),
    .core_clk_en_o(core_en), .peri_clk_en_o(peri_en), .sr_req_o(sr_req),
    .pll_en_o(pll_en), .tmr_clk_en_o(tmr_en), .irq_clk_en_o(irqc_en),
    .mode_o(mode)
  );

  // {stby,susp,wb,idle,ack,irq, mode[1:0], core,peri,sr, req_id[3:0]}
  localparam int NV = 22;
  localparam logic [14:0] VEC [NV] = '{
    {6'b000000, 2'b00, 3'b110, 4'd1 },  // R1 idle run
    {6'b100000, 2'b00, 3'b110, 4'd2 },  // R2 no writeback: ignored
    {6'b101000, 2'b00, 3'b110, 4'd2 },  // R2 accepted -> wait idle
    {6'b011000, 2'b00, 3'b110, 4'd7 },  // R7 suspend during entry ignored
    {6'b000100, 2'b01, 3'b010, 4'd3 },  // R3 idle -> standby
    {6'b111100, 2'b01, 3'b010, 4'd7 },  // R7 requests in standby ignored
    {6'b000001, 2'b00, 3'b110, 4'd4 },  // R4 irq wakes
    {6'b011000, 2'b00, 3'b111, 4'd5 },  // R5 self-refresh first
    {6'b000100, 2'b00, 3'b111, 4'd5 },  // R5 idle but no ack: wait
    {6'b000010, 2'b00, 3'b111, 4'd5 },  // R5 ack -> wait idle
    {6'b000110, 2'b10, 3'b001, 4'd5 },  // R5 suspended
    {6'b101110, 2'b10, 3'b001, 4'd7 },  // R7 request in suspend ignored
    {6'b000011, 2'b10, 3'b010, 4'd6 },  // R6 irq: peri on, sr drop
    {6'b000010, 2'b10, 3'b010, 4'd6 },  // R6 ack still high: core off
    {6'b000000, 2'b00, 3'b110, 4'd6 },  // R6 ack low -> run
    {6'b111000, 2'b00, 3'b111, 4'd9 },  // R9 both -> suspend path
    {6'b000001, 2'b00, 3'b110, 4'd8 },  // R8 abort in ack wait
    {6'b101000, 2'b00, 3'b110, 4'd8 },  // R8 standby entry
    {6'b000101, 2'b00, 3'b110, 4'd8 },  // R8 irq beats idle
    {6'b011000, 2'b00, 3'b111, 4'd8 },  // R8 suspend entry
    {6'b000010, 2'b00, 3'b111, 4'd8 },  // R8 ack -> idle wait
    {6'b000011, 2'b00, 3'b110, 4'd8 }   // R8 abort in idle wait
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {mode,core,peri,sr} act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic check_aon(); // R10
    n_chk++;
    if ({pll_en, tmr_en, irqc_en} !== 3'b111) begin
      n_err++;
      $display("FAIL R10: aon act=%b exp=111", {pll_en, tmr_en, irqc_en});
    end
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    {stby, susp, wb, idle, ack, irq} = '0;
    repeat (2) @(negedge clk);
    check("R1 reset", {mode, core_en, peri_en, sr_req}, 5'b00110);
    check_aon();
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {stby, susp, wb, idle, ack, irq} = VEC[i][14:9];
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i][3:0], i),
            {mode, core_en, peri_en, sr_req}, VEC[i][8:4]);
      check_aon();
      n_chk++;
      if (mode === 2'b11) begin  // R11
        n_err++;
        $display("FAIL R11: mode act=%b exp!=11", mode);
      end
    end
    // R1: reset taken deep in suspend
    {stby, susp, wb, idle, ack, irq} = 6'b011000;
    @(negedge clk);
    {stby, susp, wb, idle, ack, irq} = 6'b000110;
    @(negedge clk);
    @(negedge clk);
    check("R5 re-suspend", {mode, core_en, peri_en, sr_req}, 5'b10001);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async reset", {mode, core_en, peri_en, sr_req}, 5'b00110);
    @(negedge clk);
    rst_n = 1'b1;
    {stby, susp, wb, idle, ack, irq} = '0;
    @(negedge clk);
    check("R1 after release", {mode, core_en, peri_en, sr_req}, 5'b00110);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule